// File: doc/BRIEF.md
# Ethernet MII Receive FCS Checker

This block watches the receive side of a 100 Mbit/s media-independent interface, running on the 25 MHz receive clock. Each cycle with the data-valid input high carries one 4-bit nibble. The block skips the 0x5 preamble nibbles. It waits for the 0xD start-of-frame nibble. From the next nibble onward, it pairs nibbles into bytes and passes every byte through the Ethernet CRC-32. That covers the destination address through to the frame check sequence that arrived with the frame.

When data-valid drops, the frame is over. For one clock the block raises a completion strobe together with a good-FCS or alignment-error flag. It also latches two 32-bit values: the CRC it computed over the frame body, and the four trailing bytes of the frame. A debugger or a later stage can compare these two values directly. They stay valid until the next frame completes.

Top module: `mii_rx_fcs_check`

## Requirements
- R1: The first nibble of each byte pair is the low nibble (bits 3:0), and the CRC (reflected polynomial 0xEDB88320) consumes each byte least significant bit first. The body bytes "123456789" therefore give `fcs_calc` = 0xCBF43926.
- R2: Any number of 0x5 nibbles before the first 0xD nibble is discarded and never reaches the CRC. Byte assembly starts on the nibble that follows the 0xD nibble.
- R3: The CRC register is preset to all ones at every frame start, and `fcs_calc` is the inverse of the register. A body of all-zero bytes therefore yields a nonzero `fcs_calc`.
- R4: `fcs_good` is high in the completion cycle exactly when the register, after all frame bytes including the received FCS, holds 0xDEBB20E3 and the nibble count is even. 0xDEBB20E3 is the LSB-first form of the residue 0xC704DD7B.
- R5: At completion, `fcs_calc` takes the inverted CRC over all bytes except the last four. At the same time, `rx_fcs` takes the last four bytes, with the earliest of them in bits 7:0 and missing bytes as zero. Both values hold until the next completion.
- R6: `frame_done` pulses for exactly one clock, on the first rising edge at which data-valid is low after the start-of-frame nibble. If data-valid falls before any 0xD nibble, no pulse occurs.
- R7: An odd number of nibbles after the start-of-frame nibble raises `align_err` for the completion cycle and keeps `fcs_good` low. The unpaired nibble is dropped.
- R8: During and right after reset, all outputs are zero.
- R9: The CRC returns to all ones at frame end, so a bad frame does not affect the verdict on the frame that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_dv | input | 1 | Nibble valid |
| rx_nib | input | 4 | Receive nibble |
| frame_done | output | 1 | One-clock frame completion strobe |
| fcs_good | output | 1 | Received FCS matches, qualified by frame_done |
| align_err | output | 1 | Odd nibble count, qualified by frame_done |
| fcs_calc | output | 32 | Computed FCS over body bytes |
| rx_fcs | output | 32 | Last four received bytes |

## Verification
A bad preset, a swapped nibble order or a wrong bit order all show up at the first completion. The good flag fails there, and `fcs_calc` no longer matches the known value for the test string. A byte-assembly phase that drifts shows up in the same completion cycle as a false alignment error or a shifted `rx_fcs`. A CRC that is not re-armed between frames only shows up one frame later, as a bad verdict on an intact frame that follows a corrupted one. The bench compares all outputs against its model on every clock, so each of these faults is caught in the cycle where it first appears.

// File: rtl/mii_fcs_pkg.sv
package mii_fcs_pkg;
  localparam int          NIB_W        = 4;
  localparam int          CRC_W        = 32;
  localparam int          FCS_BYTES    = 4;
  localparam logic [31:0] CRC_POLY     = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE  = 32'hDEBB20E3;
  localparam logic [3:0]  NIB_SFD      = 4'hD;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_PRE  = 2'd1,
    RX_DATA = 2'd2
  } rx_state_e;
endpackage

// File: rtl/mii_nib_framer.sv
module mii_nib_framer
  import mii_fcs_pkg::*;
#(
  parameter int W     = NIB_W,
  parameter logic [W-1:0] SFD = NIB_SFD
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_dv,
  input  logic [W-1:0]   rx_nib,
  output logic           sfd_seen,
  output logic           byte_vld,
  output logic [2*W-1:0] byte_dat,
  output logic           frame_end,
  output logic           odd_nib
);
  rx_state_e    state_q, state_d;
  logic         half_q, half_d;
  logic         low_en;
  logic [W-1:0] low_q;

  always_comb begin
    state_d   = state_q;
    half_d    = half_q;
    sfd_seen  = 1'b0;
    byte_vld  = 1'b0;
    frame_end = 1'b0;
    low_en    = 1'b0;
    case (state_q)
      RX_IDLE: begin
        if (rx_dv) begin
          if (rx_nib == SFD) begin
            state_d  = RX_DATA;
            sfd_seen = 1'b1;
            half_d   = 1'b0;
          end else begin
            state_d = RX_PRE;
          end
        end
      end
      RX_PRE: begin
        if (!rx_dv) begin
          state_d = RX_IDLE;
        end else if (rx_nib == SFD) begin
          state_d  = RX_DATA;
          sfd_seen = 1'b1;
          half_d   = 1'b0;
        end
      end
      RX_DATA: begin
        if (!rx_dv) begin
          frame_end = 1'b1;
          state_d   = RX_IDLE;
          half_d    = 1'b0;
        end else if (!half_q) begin
          low_en = 1'b1;
          half_d = 1'b1;
        end else begin
          byte_vld = 1'b1;
          half_d   = 1'b0;
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  assign byte_dat = {rx_nib, low_q};
  assign odd_nib  = half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      half_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      half_q  <= half_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
    end else if (low_en) begin
      low_q <= rx_nib;
    end
  end

  // two nibbles per byte: bytes never arrive on consecutive clocks
  assert_byte_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);
  // no byte may be assembled from a nibble that preceded the delimiter
  assert_no_bytes_before_sfd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sfd_seen |=> !byte_vld);
endmodule

// File: rtl/crc32_byte_engine.sv
module crc32_byte_engine
  import mii_fcs_pkg::*;
#(
  parameter int             CW     = CRC_W,
  parameter int             BW     = 2 * NIB_W,
  parameter logic [CW-1:0]  POLY   = CRC_POLY
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          upd,
  input  logic [BW-1:0] dat,
  output logic [CW-1:0] crc_q
);
  localparam logic [CW-1:0] PRESET = '1;

  logic [CW-1:0] step;
  logic [CW-1:0] crc_d;
  logic          fb;

  always_comb begin
    step = crc_q;
    fb   = 1'b0;
    for (int i = 0; i < BW; i++) begin
      fb   = step[0] ^ dat[i];
      step = {1'b0, step[CW-1:1]} ^ (fb ? POLY : '0);
    end
  end

  always_comb begin
    crc_d = crc_q;
    if (init)      crc_d = PRESET;
    else if (upd)  crc_d = step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= PRESET;
    else        crc_q <= crc_d;
  end

  assert_preset_after_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (crc_q == PRESET));
endmodule

// File: rtl/fcs_tail_track.sv
module fcs_tail_track
  import mii_fcs_pkg::*;
#(
  parameter int CW = CRC_W,
  parameter int BW = 2 * NIB_W,
  parameter int NB = FCS_BYTES
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           push,
  input  logic [CW-1:0]  crc_in,
  input  logic [BW-1:0]  dat,
  output logic [CW-1:0]  crc_body,
  output logic [NB*BW-1:0] tail
);
  localparam int TW = NB * BW;

  logic [CW-1:0] hist_q [NB];
  logic [TW-1:0] tail_q, tail_d;

  for (genvar g = 0; g < NB; g++) begin : g_hist
    logic [CW-1:0] stage_in;
    if (g == 0) begin : g_head
      assign stage_in = crc_in;
    end else begin : g_link
      assign stage_in = hist_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hist_q[g] <= '1;
      else if (clear)  hist_q[g] <= '1;
      else if (push)   hist_q[g] <= stage_in;
    end
  end

  always_comb begin
    tail_d = tail_q;
    if (clear)      tail_d = '0;
    else if (push)  tail_d = {dat, tail_q[TW-1:BW]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tail_q <= '0;
    else        tail_q <= tail_d;
  end

  assign crc_body = hist_q[NB-1];
  assign tail     = tail_q;

  assert_tail_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (tail_q == '0));
endmodule

// File: rtl/mii_rx_fcs_check.sv
module mii_rx_fcs_check
  import mii_fcs_pkg::*;
#(
  parameter int             NW      = NIB_W,
  parameter int             CW      = CRC_W,
  parameter int             NB      = FCS_BYTES,
  parameter logic [CW-1:0]  RESIDUE = CRC_RESIDUE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_dv,
  input  logic [NW-1:0] rx_nib,
  output logic          frame_done,
  output logic          fcs_good,
  output logic          align_err,
  output logic [CW-1:0] fcs_calc,
  output logic [CW-1:0] rx_fcs
);
  localparam int BW = 2 * NW;

  logic          rst_meta_q, rst_sync_q;
  logic          sfd_seen, byte_vld, frame_end, odd_nib;
  logic [BW-1:0] byte_dat;
  logic [CW-1:0] crc_q, crc_body;
  logic [NB*BW-1:0] tail;

  logic          done_d, good_d, align_d;
  logic [CW-1:0] calc_d, rxfcs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  mii_nib_framer #(.W(NW)) i_framer (
    .clk(clk), .rst_n(rst_sync_q), .rx_dv(rx_dv), .rx_nib(rx_nib),
    .sfd_seen(sfd_seen), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .frame_end(frame_end), .odd_nib(odd_nib)
  );

  crc32_byte_engine #(.CW(CW), .BW(BW)) i_crc (
    .clk(clk), .rst_n(rst_sync_q), .init(sfd_seen | frame_end),
    .upd(byte_vld), .dat(byte_dat), .crc_q(crc_q)
  );

  fcs_tail_track #(.CW(CW), .BW(BW), .NB(NB)) i_tail (
    .clk(clk), .rst_n(rst_sync_q), .clear(sfd_seen), .push(byte_vld),
    .crc_in(crc_q), .dat(byte_dat), .crc_body(crc_body), .tail(tail)
  );

  always_comb begin
    done_d  = frame_end;
    good_d  = frame_end && !odd_nib && (crc_q == RESIDUE);
    align_d = frame_end && odd_nib;
    calc_d  = frame_end ? ~crc_body : fcs_calc;
    rxfcs_d = frame_end ? tail[CW-1:0] : rx_fcs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_done <= 1'b0;
      fcs_good   <= 1'b0;
      align_err  <= 1'b0;
      fcs_calc   <= '0;
      rx_fcs     <= '0;
    end else if (!rst_sync_q) begin
      frame_done <= 1'b0;
      fcs_good   <= 1'b0;
      align_err  <= 1'b0;
      fcs_calc   <= '0;
      rx_fcs     <= '0;
    end else begin
      frame_done <= done_d;
      fcs_good   <= good_d;
      align_err  <= align_d;
      fcs_calc   <= calc_d;
      rx_fcs     <= rxfcs_d;
    end
  end

  assert_good_needs_done_R4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    fcs_good |-> frame_done);
  assert_align_excludes_good_R7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    align_err |-> (frame_done && !fcs_good));
  assert_done_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    frame_done |=> !frame_done);
  assert_values_hold_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !frame_done |-> ($stable(fcs_calc) && $stable(rx_fcs)));
  assert_crc_rearm_R9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    frame_end |=> (crc_q == '1));
endmodule

// File: tb/test_mii_rx_fcs_check.sv
module test_mii_rx_fcs_check;
  logic        clk;
  logic        rst_n;
  logic        rx_dv;
  logic [3:0]  rx_nib;
  logic        frame_done, fcs_good, align_err;
  logic [31:0] fcs_calc, rx_fcs;

  int n_checks;
  int n_fail;

  mii_rx_fcs_check i_mii_rx_fcs_check (
    .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_nib(rx_nib),
    .frame_done(frame_done), .fcs_good(fcs_good), .align_err(align_err),
    .fcs_calc(fcs_calc), .rx_fcs(rx_fcs)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- behavioural reference ----------------
  int          m_state;
  logic [3:0]  m_nibs[$];
  logic        e_done, e_good, e_align;
  logic [31:0] e_calc, e_fcs;

  function automatic logic [31:0] ref_crc(input logic [7:0] b[$], input int n);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 8; k++) begin
        if (c[0] ^ b[i][k]) c = (c >> 1) ^ 32'hEDB88320;
        else                c = c >> 1;
      end
    end
    return c;
  endfunction

  task automatic model_close();
    logic [7:0] bq[$];
    int nb;
    logic odd;
    nb  = m_nibs.size() / 2;
    odd = (m_nibs.size() % 2) != 0;
    for (int i = 0; i < nb; i++) bq.push_back({m_nibs[2*i+1], m_nibs[2*i]});
    e_done  = 1'b1;
    e_align = odd;
    e_good  = !odd && (ref_crc(bq, nb) == 32'hDEBB20E3);
    e_calc  = ~ref_crc(bq, (nb > 4) ? nb - 4 : 0);
    e_fcs   = '0;
    for (int i = 0; i < 4; i++)
      if (nb - 4 + i >= 0) e_fcs[8*i +: 8] = bq[nb-4+i];
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_nibs.delete();
      e_done = 0; e_good = 0; e_align = 0; e_calc = '0; e_fcs = '0;
    end else begin
      e_done = 0; e_good = 0; e_align = 0;
      case (m_state)
        0: if (rx_dv) begin
             if (rx_nib == 4'hD) begin m_state = 2; m_nibs.delete(); end
             else m_state = 1;
           end
        1: if (!rx_dv) m_state = 0;
           else if (rx_nib == 4'hD) begin m_state = 2; m_nibs.delete(); end
        default: if (!rx_dv) begin model_close(); m_state = 0; end
                 else m_nibs.push_back(rx_nib);
      endcase
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 frame_done", {31'b0, frame_done}, {31'b0, e_done});
      chk("R4 fcs_good",   {31'b0, fcs_good},   {31'b0, e_good});
      chk("R7 align_err",  {31'b0, align_err},  {31'b0, e_align});
      chk("R5 fcs_calc",   fcs_calc, e_calc);
      chk("R5 rx_fcs",     rx_fcs,   e_fcs);
    end
  end

  // ---------------- stimulus ----------------
  logic last_done, last_good, last_align;

  task automatic put_nib(input logic [3:0] v);
    @(negedge clk);
    rx_dv  = 1'b1;
    rx_nib = v;
  endtask

  task automatic send_frame(input int npre, input logic [7:0] body[$],
                            input bit add_fcs, input bit flip, input bit extra_nib);
    logic [7:0] fr[$];
    logic [31:0] f;
    fr = body;
    if (add_fcs) begin
      f = ~ref_crc(body, body.size());
      for (int i = 0; i < 4; i++) fr.push_back(f[8*i +: 8]);
    end
    if (flip && fr.size() > 0) fr[0] = fr[0] ^ 8'h01;
    for (int i = 0; i < npre; i++) put_nib(4'h5);
    put_nib(4'hD);
    foreach (fr[i]) begin
      put_nib(fr[i][3:0]);
      put_nib(fr[i][7:4]);
    end
    if (extra_nib) put_nib(4'hA);
    @(negedge clk);
    rx_dv  = 1'b0;
    rx_nib = 4'h0;
    @(negedge clk);
    last_done  = frame_done;
    last_good  = fcs_good;
    last_align = align_err;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    rx_dv    = 1'b0;
    rx_nib   = 4'h0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    // R8: outputs during reset
    chk("R8 reset done", {31'b0, frame_done}, 32'd0);
    chk("R8 reset calc", fcs_calc, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 post-reset fcs", rx_fcs, 32'd0);
    chk("R8 post-reset good", {31'b0, fcs_good}, 32'd0);
  end

  initial begin : main
    logic [7:0] d[$];
    logic [7:0] lf;
    wait (rst_n === 1'b1);
    repeat (6) @(negedge clk);

    // R1: known string, long preamble
    d = {8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    send_frame(15, d, 1, 0, 0);
    chk("R1 check string crc", fcs_calc, 32'hCBF43926);
    chk("R4 intact frame good", {31'b0, last_good}, 32'd1);
    chk("R5 calc equals received", rx_fcs, fcs_calc);

    // R2: short preamble, same verdict
    send_frame(3, d, 1, 0, 0);
    chk("R2 short preamble good", {31'b0, last_good}, 32'd1);
    send_frame(0, d, 1, 0, 0);
    chk("R2 no preamble good", {31'b0, last_good}, 32'd1);

    // R3: all-zero body
    d = {};
    for (int i = 0; i < 8; i++) d.push_back(8'h00);
    send_frame(7, d, 1, 0, 0);
    chk("R3 zero body crc nonzero", {31'b0, (fcs_calc != 32'd0)}, 32'd1);
    chk("R3 zero body good", {31'b0, last_good}, 32'd1);

    // R4 / R9: corrupted then intact
    send_frame(7, d, 1, 1, 0);
    chk("R4 corrupted bad", {31'b0, last_good}, 32'd0);
    chk("R4 corrupted done", {31'b0, last_done}, 32'd1);
    send_frame(7, d, 1, 0, 0);
    chk("R9 good after bad", {31'b0, last_good}, 32'd1);

    // R7: odd nibble count
    send_frame(7, d, 1, 0, 1);
    chk("R7 odd align", {31'b0, last_align}, 32'd1);
    chk("R7 odd not good", {31'b0, last_good}, 32'd0);

    // R6: preamble only, no strobe; values held
    for (int i = 0; i < 6; i++) put_nib(4'h5);
    @(negedge clk); rx_dv = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R6 no strobe without sfd", {31'b0, frame_done}, 32'd0);
    end

    // R5: short frame tail placement
    d = {8'h12, 8'h34};
    send_frame(7, d, 0, 0, 0);
    chk("R5 short tail", rx_fcs, 32'h34120000);
    chk("R5 short calc", fcs_calc, 32'h00000000);

    // varied frames checked by the per-clock model
    lf = 8'hA5;
    for (int f = 0; f < 20; f++) begin
      d = {};
      for (int i = 0; i < 4 + f * 3; i++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        d.push_back(lf);
      end
      send_frame(f % 8, d, 1, (f % 5) == 2, (f % 7) == 3);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule